// File: doc/BRIEF.md
# DSI Video-Mode Packet Sequencer

This block produces the byte stream for one display frame after another on a DSI transmitter running in sync-event video mode. Each line is a sync short packet followed by three long packets: back-porch blanking, the active region and front-porch blanking. Each long packet has a four-byte header (data identifier, 16-bit word count sent low byte first, and an error-correcting byte), a payload, and a CRC-16 footer. Software sets the porch payload sizes and the vertical region line counts. The line time therefore comes out in byte clocks.

Bytes leave one per clock on `byte_o` and go to a downstream lane distributor. Pixel payload bytes come from an upstream stream with a valid/ready handshake. When pixel data is missing, the sequencer stalls without emitting anything. Dropping `run_i` freezes it in place.

Top module: `dsi_vid_seq`

## Requirements
- R1: Every line is emitted in this order: sync short packet, back-porch long packet, active-region long packet, front-porch long packet. A line is exactly 22 + hbp + hact + hfp bytes long.
- R2: A long-packet header is the data identifier, then the word count low byte, then the word count high byte, then the ECC byte. A sync packet uses the same layout with both data bytes 0x00. Both porch packets use identifier 0x19, with word counts taken from `hbp_wc_i` and `hfp_wc_i`.
- R3: ECC bit k (k = 0..5) is the XOR-parity of the 24-bit header value {byte2, byte1, byte0} ANDed with 0xF12CB7, 0xF2555B, 0x749A6D, 0xB8E38E, 0xDF03F0 and 0xEFFC00 in that order. ECC bits 7:6 are zero.
- R4: The footer is a CRC-16 over the payload bytes only. It uses the reflected polynomial 0x8408 (x^16+x^12+x^5+1), processes bits LSB first, starts from 0xFFFF and is sent low byte first. An empty payload gives 0xFFFF.
- R5: The sync packet of line 0 of each frame uses identifier 0x01. Every other line uses 0x21.
- R6: A frame is vsa, then vbp, then vact, then vfp lines, and then line 0 follows again. On the vact lines the third packet has identifier 0x3E and carries pixel bytes. On all other lines it has identifier 0x19 and carries hact bytes of 0x00. Porch payloads are always 0x00.
- R7: Pixel bytes are consumed in arrival order, one per active payload byte, and exactly hact per active line. `pix_rdy_o` is high only while an active payload byte is due. If `pix_vld_i` is low at that point, no byte is emitted and the position is held.
- R8: While `run_i` is low no byte is emitted and the sequencer position is held. The line resumes intact afterwards.
- R9: After reset `byte_vld_o` and `pix_rdy_o` are low, and the first byte emitted is the start of line 0.
- R10: `sop_o` marks the first byte of each packet. `sof_o` marks the first byte of line 0. `eol_o` marks the last byte of each line. All three are qualified by `byte_vld_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Advance enable; low freezes the sequencer |
| hact_wc_i | input | WC_W | Active-region payload bytes per line |
| hbp_wc_i | input | WC_W | Back-porch payload bytes |
| hfp_wc_i | input | WC_W | Front-porch payload bytes |
| vsa_i | input | LINE_W | Sync-region lines |
| vbp_i | input | LINE_W | Vertical back-porch lines |
| vact_i | input | LINE_W | Active lines |
| vfp_i | input | LINE_W | Vertical front-porch lines |
| pix_byte_i | input | 8 | Pixel payload byte |
| pix_vld_i | input | 1 | Pixel byte valid |
| pix_rdy_o | output | 1 | Pixel byte accepted when high with valid |
| byte_o | output | 8 | Output stream byte |
| byte_vld_o | output | 1 | Output byte valid |
| sop_o | output | 1 | First byte of a packet |
| eol_o | output | 1 | Last byte of a line |
| sof_o | output | 1 | First byte of a frame |

## Verification
The bench targets the following corner cases:
- Zero-length porches. A design that mishandled them would emit stray payload bytes or a CRC other than 0xFFFF.
- A zero active word count, which would do the same.
- An empty sync region. A wrong design would lose the 0x01 identifier on line 0.
- The frame wrap. A wrong design would put the 0x01 identifier on the wrong line or run an extra line.
- Pixel underrun and a mid-line pause. A design that advanced during either would shift pixels, emit filler bytes or break the line length.
- Header ECC and payload CRC, which are compared against reference calculations of a different form from the design's.

// File: rtl/dsi_seq_pkg.sv
package dsi_seq_pkg;
  localparam logic [7:0] DI_VSYNC = 8'h01;
  localparam logic [7:0] DI_HSYNC = 8'h21;
  localparam logic [7:0] DI_BLANK = 8'h19;
  localparam logic [7:0] DI_RGB24 = 8'h3E;
  localparam logic [7:0] FILL_BYTE = 8'h00;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_POLY = 16'h8408;

  typedef enum logic [1:0] {PK_SYNC, PK_HBP, PK_HACT, PK_HFP} pkt_e;
  typedef enum logic [1:0] {PH_HDR, PH_PAY, PH_CRC} phase_e;
  typedef enum logic [1:0] {LN_VSA, LN_VBP, LN_ACT, LN_VFP} line_e;
endpackage

// File: rtl/dsi_ecc.sv
module dsi_ecc (
  input  logic [23:0] hdr_i,
  output logic [7:0]  ecc_o
);
  logic [5:0] p;
  logic [23:0] d;
  assign d = hdr_i;
  assign p[0] = d[0]^d[1]^d[2]^d[4]^d[5]^d[7]^d[10]^d[11]^d[13]^d[16]^d[20]^d[21]^d[22]^d[23];
  assign p[1] = d[0]^d[1]^d[3]^d[4]^d[6]^d[8]^d[10]^d[12]^d[14]^d[17]^d[20]^d[21]^d[22]^d[23];
  assign p[2] = d[0]^d[2]^d[3]^d[5]^d[6]^d[9]^d[11]^d[12]^d[15]^d[18]^d[20]^d[21]^d[22];
  assign p[3] = d[1]^d[2]^d[3]^d[7]^d[8]^d[9]^d[13]^d[14]^d[15]^d[19]^d[20]^d[21]^d[23];
  assign p[4] = d[4]^d[5]^d[6]^d[7]^d[8]^d[9]^d[16]^d[17]^d[18]^d[19]^d[20]^d[22]^d[23];
  assign p[5] = d[10]^d[11]^d[12]^d[13]^d[14]^d[15]^d[16]^d[17]^d[18]^d[19]^d[21]^d[22]^d[23];
  assign ecc_o = {2'b00, p};
endmodule

// File: rtl/dsi_crc16.sv
module dsi_crc16 import dsi_seq_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q, crc_n;

  always_comb begin
    crc_n = crc_q;
    for (int i = 0; i < 8; i++) begin
      if (crc_n[0] ^ data_i[i]) crc_n = (crc_n >> 1) ^ CRC_POLY;
      else                      crc_n = crc_n >> 1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= CRC_SEED;
    else if (clr_i) crc_q <= CRC_SEED;
    else if (en_i)  crc_q <= crc_n;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/dsi_line_ctrl.sv
module dsi_line_ctrl import dsi_seq_pkg::*; #(
  parameter int LINE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [LINE_W-1:0] vsa_i,
  input  logic [LINE_W-1:0] vbp_i,
  input  logic [LINE_W-1:0] vact_i,
  input  logic [LINE_W-1:0] vfp_i,
  output line_e             kind_o,
  output logic              first_o
);
  localparam int SUM_W = LINE_W + 2;

  logic [SUM_W-1:0] ln_q, ln_inc, b_sync, b_bp, b_act, b_tot;

  assign b_sync = SUM_W'(vsa_i);
  assign b_bp   = b_sync + SUM_W'(vbp_i);
  assign b_act  = b_bp + SUM_W'(vact_i);
  assign b_tot  = b_act + SUM_W'(vfp_i);
  assign ln_inc = ln_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ln_q <= '0;
    else if (adv_i) ln_q <= (ln_inc >= b_tot) ? '0 : ln_inc;
  end

  always_comb begin
    if (ln_q < b_sync)     kind_o = LN_VSA;
    else if (ln_q < b_bp)  kind_o = LN_VBP;
    else if (ln_q < b_act) kind_o = LN_ACT;
    else                   kind_o = LN_VFP;
  end

  assign first_o = (ln_q == '0);
endmodule

// File: rtl/dsi_vid_seq.sv
module dsi_vid_seq import dsi_seq_pkg::*; #(
  parameter int WC_W   = 16,
  parameter int LINE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [WC_W-1:0]   hact_wc_i,
  input  logic [WC_W-1:0]   hbp_wc_i,
  input  logic [WC_W-1:0]   hfp_wc_i,
  input  logic [LINE_W-1:0] vsa_i,
  input  logic [LINE_W-1:0] vbp_i,
  input  logic [LINE_W-1:0] vact_i,
  input  logic [LINE_W-1:0] vfp_i,
  input  logic [7:0]        pix_byte_i,
  input  logic              pix_vld_i,
  output logic              pix_rdy_o,
  output logic [7:0]        byte_o,
  output logic              byte_vld_o,
  output logic              sop_o,
  output logic              eol_o,
  output logic              sof_o
);
  pkt_e              pkt_q, pkt_d;
  phase_e            ph_q, ph_d;
  logic [WC_W-1:0]   cnt_q, cnt_d, cur_wc;
  logic [15:0]       wc_f;
  logic [7:0]        di, ecc, byte_d;
  logic [15:0]       crc;
  line_e             kind;
  logic              first_line, act_line, pay_pix, adv;
  logic              hdr_last, pay_last, crc_last, pkt_end, line_end;

  always_comb begin
    unique case (pkt_q)
      PK_HBP:  cur_wc = hbp_wc_i;
      PK_HACT: cur_wc = hact_wc_i;
      PK_HFP:  cur_wc = hfp_wc_i;
      default: cur_wc = '0;
    endcase
  end

  assign act_line = (kind == LN_ACT);
  assign wc_f     = 16'(cur_wc);

  always_comb begin
    unique case (pkt_q)
      PK_SYNC: di = first_line ? DI_VSYNC : DI_HSYNC;
      PK_HACT: di = act_line ? DI_RGB24 : DI_BLANK;
      default: di = DI_BLANK;
    endcase
  end

  dsi_ecc u_ecc (.hdr_i({wc_f, di}), .ecc_o(ecc));

  assign pay_pix   = (ph_q == PH_PAY) && (pkt_q == PK_HACT) && act_line;
  assign pix_rdy_o = run_i && pay_pix;
  assign adv       = run_i && (!pay_pix || pix_vld_i);

  assign hdr_last = (ph_q == PH_HDR) && (cnt_q == WC_W'(3));
  assign pay_last = (ph_q == PH_PAY) && (({1'b0, cnt_q} + 1'b1) == {1'b0, cur_wc});
  assign crc_last = (ph_q == PH_CRC) && cnt_q[0];
  assign pkt_end  = (hdr_last && (pkt_q == PK_SYNC)) || crc_last;
  assign line_end = pkt_end && (pkt_q == PK_HFP);

  always_comb begin
    unique case (ph_q)
      PH_HDR: begin
        unique case (cnt_q[1:0])
          2'd0:    byte_d = di;
          2'd1:    byte_d = wc_f[7:0];
          2'd2:    byte_d = wc_f[15:8];
          default: byte_d = ecc;
        endcase
      end
      PH_PAY:  byte_d = pay_pix ? pix_byte_i : FILL_BYTE;
      default: byte_d = cnt_q[0] ? crc[15:8] : crc[7:0];
    endcase
  end

  always_comb begin
    pkt_d = pkt_q;
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_HDR: begin
        if (!hdr_last) cnt_d = cnt_q + 1'b1;
        else begin
          cnt_d = '0;
          if (pkt_q == PK_SYNC) pkt_d = PK_HBP;
          else if (cur_wc == '0) ph_d = PH_CRC;
          else ph_d = PH_PAY;
        end
      end
      PH_PAY: begin
        if (pay_last) begin
          ph_d  = PH_CRC;
          cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      default: begin
        if (!cnt_q[0]) cnt_d = WC_W'(1);
        else begin
          cnt_d = '0;
          ph_d  = PH_HDR;
          pkt_d = pkt_e'(pkt_q + 2'd1);  // HFP wraps to SYNC
        end
      end
    endcase
  end

  dsi_crc16 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (adv && (ph_q == PH_HDR)),
    .en_i   (adv && (ph_q == PH_PAY)),
    .data_i (byte_d),
    .crc_o  (crc)
  );

  dsi_line_ctrl #(.LINE_W(LINE_W)) u_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (adv && line_end),
    .vsa_i   (vsa_i),
    .vbp_i   (vbp_i),
    .vact_i  (vact_i),
    .vfp_i   (vfp_i),
    .kind_o  (kind),
    .first_o (first_line)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_q <= PK_SYNC;
      ph_q  <= PH_HDR;
      cnt_q <= '0;
    end else if (adv) begin
      pkt_q <= pkt_d;
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
      sop_o      <= 1'b0;
      eol_o      <= 1'b0;
      sof_o      <= 1'b0;
    end else begin
      byte_vld_o <= adv;
      sop_o      <= adv && (ph_q == PH_HDR) && (cnt_q == '0);
      sof_o      <= adv && (ph_q == PH_HDR) && (cnt_q == '0) && (pkt_q == PK_SYNC) && first_line;
      eol_o      <= adv && line_end;
      if (adv) byte_o <= byte_d;
    end
  end
endmodule

// File: rtl/dsi_vid_seq_chk.sv
module dsi_vid_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       run_i,
  input logic       pix_vld_i,
  input logic       pix_rdy_o,
  input logic [7:0] byte_o,
  input logic       byte_vld_o,
  input logic       sop_o,
  input logic       eol_o,
  input logic       sof_o
);
  a_r7_rdy_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_rdy_o |-> run_i);
  a_r7_underrun_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_rdy_o && !pix_vld_i) |=> !byte_vld_o);
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !byte_vld_o);
  a_r10_sof_is_sop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> (sop_o && byte_vld_o));
  a_r10_sop_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_o |-> byte_vld_o);
  a_r10_eol_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o |-> (byte_vld_o && !sop_o));
  a_r5_sof_vsync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> (byte_o == 8'h01));
endmodule

bind dsi_vid_seq dsi_vid_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_i),
  .pix_vld_i  (pix_vld_i),
  .pix_rdy_o  (pix_rdy_o),
  .byte_o     (byte_o),
  .byte_vld_o (byte_vld_o),
  .sop_o      (sop_o),
  .eol_o      (eol_o),
  .sof_o      (sof_o)
);

// File: tb/sim_dsi_vid_seq.sv
`timescale 1ns/1ps
module sim_dsi_vid_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni, run_i, pix_vld_i, pix_rdy_o, byte_vld_o, sop_o, eol_o, sof_o;
  logic [15:0] hact_wc_i, hbp_wc_i, hfp_wc_i;
  logic [11:0] vsa_i, vbp_i, vact_i, vfp_i;
  logic [7:0]  pix_byte_i, byte_o;

  dsi_vid_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i),
    .hact_wc_i(hact_wc_i), .hbp_wc_i(hbp_wc_i), .hfp_wc_i(hfp_wc_i),
    .vsa_i(vsa_i), .vbp_i(vbp_i), .vact_i(vact_i), .vfp_i(vfp_i),
    .pix_byte_i(pix_byte_i), .pix_vld_i(pix_vld_i), .pix_rdy_o(pix_rdy_o),
    .byte_o(byte_o), .byte_vld_o(byte_vld_o), .sop_o(sop_o), .eol_o(eol_o), .sof_o(sof_o)
  );

  typedef struct packed {
    logic [15:0] hbp; logic [15:0] hact; logic [15:0] hfp;
    logic [11:0] vsa; logic [11:0] vbp; logic [11:0] vact; logic [11:0] vfp;
    logic stall;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VEC [NV] = '{
    '{hbp:16'd3,  hact:16'd6,  hfp:16'd2, vsa:12'd1, vbp:12'd1, vact:12'd2, vfp:12'd1, stall:1'b0},
    '{hbp:16'd0,  hact:16'd9,  hfp:16'd0, vsa:12'd2, vbp:12'd0, vact:12'd3, vfp:12'd1, stall:1'b1},
    '{hbp:16'd5,  hact:16'd0,  hfp:16'd4, vsa:12'd0, vbp:12'd2, vact:12'd1, vfp:12'd2, stall:1'b0},
    '{hbp:16'd12, hact:16'd24, hfp:16'd7, vsa:12'd1, vbp:12'd1, vact:12'd4, vfp:12'd1, stall:1'b1}
  };

  vec_t cv;
  logic [7:0] seed;
  logic mon_clear;
  int checks = 0, errors = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // pixel source
  logic [7:0] lfsr;
  int acc_total;
  always @(posedge clk) begin
    if (mon_clear) begin
      pix_byte_i <= seed;
      acc_total  <= 0;
      lfsr       <= 8'hA5;
      pix_vld_i  <= 1'b1;
    end else begin
      if (pix_rdy_o && pix_vld_i) begin
        pix_byte_i <= pix_byte_i + 8'd1;
        acc_total  <= acc_total + 1;
      end
      lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      pix_vld_i <= cv.stall ? (lfsr[0] | lfsr[2]) : 1'b1;
    end
  end

  logic run_at_edge;
  always @(posedge clk) run_at_edge <= run_i;

  // reference model
  function automatic logic [7:0] ref_ecc(logic [23:0] h);
    logic [23:0] m [6];
    logic [7:0] r;
    m = '{24'hF12CB7, 24'hF2555B, 24'h749A6D, 24'hB8E38E, 24'hDF03F0, 24'hEFFC00};
    r = 8'h00;
    for (int k = 0; k < 6; k++) r[k] = ^(h & m[k]);
    return r;
  endfunction

  function automatic logic [15:0] crc_step(logic [15:0] c, logic [7:0] b);
    logic [7:0] x;
    x = b ^ c[7:0];
    x = x ^ (x << 4);
    return (c >> 8) ^ {x, 8'h00} ^ {5'b0, x, 3'b0} ^ {12'b0, x[7:4]};
  endfunction

  // entry: {tag[2:0], sof, sop, byte}; tags 0 hdr,1 ecc,2 payload,3 crc,4 sync id
  logic [12:0] exp_q [$];
  int pos, exp_len, m_line, lines_done, acc_mark, pause_viol, m_checks, m_errors;
  logic [7:0] m_pix;
  bit m_act;
  bit bad [6];
  logic [7:0] bad_a [6];
  logic [7:0] bad_e [6];

  task automatic mchk(bit ok, string req, string what, int act, int exp);
    m_checks++;
    if (!ok) begin
      m_errors++;
      $display("FAIL %s %s line=%0d actual=%0h expected=%0h", req, what, m_line, act, exp);
    end
  endtask

  task automatic push_hdr(logic [7:0] di, logic [15:0] wc, bit sync, bit sof);
    exp_q.push_back({sync ? 3'd4 : 3'd0, sof, 1'b1, di});
    exp_q.push_back({3'd0, 2'b00, wc[7:0]});
    exp_q.push_back({3'd0, 2'b00, wc[15:8]});
    exp_q.push_back({3'd1, 2'b00, ref_ecc({wc, di})});
  endtask

  task automatic push_long(logic [7:0] di, logic [15:0] wc, bit pix);
    logic [15:0] c;
    logic [7:0] b;
    push_hdr(di, wc, 1'b0, 1'b0);
    c = 16'hFFFF;
    for (int j = 0; j < int'(wc); j++) begin
      b = pix ? m_pix : 8'h00;
      if (pix) m_pix = m_pix + 8'd1;
      c = crc_step(c, b);
      exp_q.push_back({3'd2, 2'b00, b});
    end
    exp_q.push_back({3'd3, 2'b00, c[7:0]});
    exp_q.push_back({3'd3, 2'b00, c[15:8]});
  endtask

  task automatic build_line(int ln);
    int a, b, c;
    a = int'(cv.vsa);
    b = a + int'(cv.vbp);
    c = b + int'(cv.vact);
    m_act = (ln >= b) && (ln < c);
    push_hdr((ln == 0) ? 8'h01 : 8'h21, 16'h0000, 1'b1, ln == 0);
    push_long(8'h19, cv.hbp, 1'b0);
    push_long(m_act ? 8'h3E : 8'h19, cv.hact, m_act);
    push_long(8'h19, cv.hfp, 1'b0);
    exp_len = exp_q.size();
  endtask

  always @(negedge clk) begin
    if (mon_clear) begin
      exp_q.delete();
      pos = 0; m_line = 0; lines_done = 0; acc_mark = 0; pause_viol = 0;
      m_pix = seed;
      for (int i = 0; i < 6; i++) bad[i] = 1'b0;
    end else begin
      if (!run_at_edge && byte_vld_o) pause_viol++;
      if (byte_vld_o) begin
        logic [12:0] e;
        if (exp_q.size() == 0) build_line(m_line);
        e = exp_q.pop_front();
        pos++;
        if (byte_o != e[7:0] && !bad[e[12:10]]) begin
          bad[e[12:10]] = 1'b1; bad_a[e[12:10]] = byte_o; bad_e[e[12:10]] = e[7:0];
        end
        if (({sof_o, sop_o} != e[9:8] || (exp_q.size() == 0) != eol_o) && !bad[5]) begin
          bad[5] = 1'b1; bad_a[5] = {5'b0, eol_o, sof_o, sop_o};
          bad_e[5] = {5'b0, exp_q.size() == 0, e[9:8]};
        end
        if (eol_o) begin
          int tot;
          mchk(pos == exp_len && exp_q.size() == 0, "R1", "line length", pos, exp_len);
          mchk(!bad[0], "R2", "header byte", bad_a[0], bad_e[0]);
          mchk(!bad[1], "R3", "ecc byte", bad_a[1], bad_e[1]);
          mchk(!bad[2], "R6", "payload byte", bad_a[2], bad_e[2]);
          mchk(!bad[3], "R4", "crc byte", bad_a[3], bad_e[3]);
          mchk(!bad[4], "R5", "sync identifier", bad_a[4], bad_e[4]);
          mchk(!bad[5], "R10", "markers eol/sof/sop", bad_a[5], bad_e[5]);
          mchk(acc_total - acc_mark == (m_act ? int'(cv.hact) : 0), "R7", "pixels taken",
               acc_total - acc_mark, m_act ? int'(cv.hact) : 0);
          acc_mark = acc_total;
          exp_q.delete();
          for (int i = 0; i < 6; i++) bad[i] = 1'b0;
          pos = 0;
          lines_done++;
          tot = int'(cv.vsa) + int'(cv.vbp) + int'(cv.vact) + int'(cv.vfp);
          m_line = (m_line + 1 >= tot) ? 0 : m_line + 1;
        end
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks + m_checks + 1, errors + m_errors + 1);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; run_i = 1'b0; mon_clear = 1'b1; seed = 8'h40; cv = VEC[0];
    hact_wc_i = '0; hbp_wc_i = '0; hfp_wc_i = '0;
    vsa_i = '0; vbp_i = '0; vact_i = '0; vfp_i = '0;
    for (int v = 0; v < NV; v++) begin
      int tot, wait_c;
      cv = VEC[v];
      seed = 8'h40 + 8'(v * 37);
      hbp_wc_i = cv.hbp; hact_wc_i = cv.hact; hfp_wc_i = cv.hfp;
      vsa_i = cv.vsa; vbp_i = cv.vbp; vact_i = cv.vact; vfp_i = cv.vfp;
      run_i = 1'b0;
      mon_clear = 1'b1;
      @(negedge clk); rst_ni = 1'b0;
      repeat (3) @(negedge clk);
      rst_ni = 1'b1;
      repeat (4) @(negedge clk);
      // R9: idle after reset
      chk(byte_vld_o == 1'b0, "R9", "byte_vld_o after reset", byte_vld_o, 0);
      chk(pix_rdy_o == 1'b0, "R9", "pix_rdy_o after reset", pix_rdy_o, 0);
      mon_clear = 1'b0;
      @(negedge clk);
      run_i = 1'b1;
      if (v == 3) begin
        // R8: mid-line pause
        repeat (30) @(negedge clk);
        run_i = 1'b0;
        repeat (20) @(negedge clk);
        run_i = 1'b1;
      end
      tot = int'(cv.vsa) + int'(cv.vbp) + int'(cv.vact) + int'(cv.vfp);
      wait_c = 0;
      while (lines_done < tot + 1 && wait_c < 20000) begin
        @(negedge clk);
        wait_c++;
      end
      chk(lines_done >= tot + 1, "R6", "frame plus wrap line completed", lines_done, tot + 1);
      if (v == 3) chk(pause_viol == 0, "R8", "bytes while paused", pause_viol, 0);
      run_i = 1'b0;
      repeat (3) @(negedge clk);
      chk(byte_vld_o == 1'b0, "R8", "quiet after run low", byte_vld_o, 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks + m_checks, errors + m_errors);
    $finish;
  end
endmodule